// File: doc/BRIEF.md
# Receive Character Buffer with Status Word

This block sits between the serial deserializer of an asynchronous receiver and a processor bus. Each character that the deserializer finishes is pushed in with its own error flags: framing, parity and line break. The block holds the characters in a small first-in first-out store. The bus sees a single 16-bit word. Its upper byte holds status, and its lower byte holds the oldest unread character. Each read strobe removes that character.

The status byte has two parts. The first part describes the store: full, at least half full, holding data, and holding data that has waited too long. The second part describes the character currently shown. If a character arrives while the store is full, it replaces the newest stored entry and is marked with an overrun bit. This way, software learns that something was lost. A bit-time tick drives an age counter. The counter raises a stale-data flag when characters sit unread for more than 30 bit times, even if the fill level never reaches the half mark. Each of the four store flags drives its own interrupt request, gated by its own enable input.

Top module: `rxStatusFifo`

## Requirements
- R1: `readWord` is laid out as {full[15], half[14], ready[13], old[12], overrun[11], frameErr[10], parityErr[9], breakDet[8], data[7:0]}. During and right after reset it reads 0x0000.
- R2: Bit 13 (ready) is 1 exactly when at least one character is stored. While it is 0, bits 12 to 0 read zero.
- R3: Bit 15 (full) is 1 exactly when all `DEPTH` entries (default 8) are occupied.
- R4: Bit 14 (half) is 1 exactly when `HALF_FREE` (default 4) or fewer entries are free.
- R5: A read strobe while ready is 1 removes the shown character. Characters come out in arrival order, and each keeps its own frame, parity and break flags.
- R6: A push while full, with no read in the same cycle, replaces the newest stored entry with the arriving character and sets bit 11 of that entry. Older entries are kept unchanged, and the occupancy does not change.
- R7: A read strobe while ready is 0 changes nothing: the word and all later reads stay as if the strobe never happened.
- R8: Bit 12 (old) is set once more than `AGE_LIMIT` (default 30) tick pulses have arrived since the last restart while data was stored. The count restarts on every read that removes a character and on every push into an empty store. A removing read therefore clears old.
- R9: A push and a read in the same cycle on a non-empty store leave the occupancy unchanged. This also holds when the store is full, and in that case no overrun is tagged.
- R10: Each of `irqFull`, `irqHalf`, `irqReady` and `irqOld` equals its status bit ANDed with its own enable input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pushValid | input | 1 | A received character is offered this cycle |
| pushData | input | 8 | Received character |
| pushFrameErr | input | 1 | Framing error of the character |
| pushParityErr | input | 1 | Parity error of the character |
| pushBreak | input | 1 | Line break detected with the character |
| bitTick | input | 1 | One pulse per serial bit time |
| readStrobe | input | 1 | Bus read of the word; removes the shown character |
| enFull | input | 1 | Enable for the full interrupt |
| enHalf | input | 1 | Enable for the half interrupt |
| enReady | input | 1 | Enable for the ready interrupt |
| enOld | input | 1 | Enable for the stale-data interrupt |
| readWord | output | 16 | Status and oldest character |
| irqFull | output | 1 | Full interrupt request |
| irqHalf | output | 1 | Half interrupt request |
| irqReady | output | 1 | Ready interrupt request |
| irqOld | output | 1 | Stale-data interrupt request |

## Verification
The store is filled with characters whose data and flag patterns all differ, so that any mix-up of order or flags shows when it is drained. Overflow bursts with and without a read in the same cycle tell the overwrite-and-tag path apart from the normal exchange path. Tick trains of exactly 30 and 31 pulses mark the stale-data threshold. A train interrupted by a read, and a push into a non-empty store, show which events restart the age count. Reads of an empty store and rotating enable patterns check that the pointers stay still and that each interrupt is gated on its own.

// File: rtl/rxStatusFifoPkg.sv
package rxStatusFifoPkg;
  // One stored character with its own status
  typedef struct packed {
    logic       overrun;
    logic       frameErr;
    logic       parityErr;
    logic       breakDet;
    logic [7:0] data;
  } rxEntry_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic wrEn;   // append at tail
    logic ovwr;   // replace newest entry, tag overrun
    logic popEn;  // advance head
  } fifoStrobes_t;
endpackage

// File: rtl/rxFifoCtrl.sv
module rxFifoCtrl
  import rxStatusFifoPkg::*;
#(
  parameter int DEPTH     = 8,
  parameter int HALF_FREE = 4,
  parameter int AGE_LIMIT = 30
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         pushValid,
  input  logic         readStrobe,
  input  logic         bitTick,
  output fifoStrobes_t strb,
  output logic         isFull,
  output logic         isHalf,
  output logic         isReady,
  output logic         isOld
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int AGE_W = $clog2(AGE_LIMIT + 2);

  logic [CNT_W-1:0] count;
  logic [AGE_W-1:0] ageCnt;
  logic             ageClr;
  logic             ageInc;

  assign isReady = (count != '0);
  assign isFull  = (count == CNT_W'(DEPTH));
  assign isHalf  = (DEPTH - int'(count)) <= HALF_FREE;
  assign isOld   = isReady && (int'(ageCnt) > AGE_LIMIT);

  always_comb begin
    strb.popEn = readStrobe && isReady;
    strb.wrEn  = pushValid && (!isFull || strb.popEn);
    strb.ovwr  = pushValid && isFull && !strb.popEn;
  end

  assign ageClr = strb.popEn || (pushValid && !isReady);
  assign ageInc = bitTick && isReady && (int'(ageCnt) <= AGE_LIMIT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0;
    end else begin
      count <= count + CNT_W'(strb.wrEn) - CNT_W'(strb.popEn);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ageCnt <= '0;
    end else if (ageClr) begin
      ageCnt <= '0;
    end else if (ageInc) begin
      ageCnt <= ageCnt + AGE_W'(1);
    end
  end
endmodule

// File: rtl/rxFifoData.sv
module rxFifoData
  import rxStatusFifoPkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  fifoStrobes_t strb,
  input  rxEntry_t     inEntry,
  output rxEntry_t     headEntry
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  rxEntry_t         mem [DEPTH];
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;
  logic [PTR_W-1:0] newestPtr;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + PTR_W'(1);
  endfunction

  assign newestPtr = (wrPtr == '0) ? LAST : wrPtr - PTR_W'(1);
  assign headEntry = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (strb.wrEn) begin
      mem[wrPtr]         <= inEntry;
      mem[wrPtr].overrun <= 1'b0;
    end else if (strb.ovwr) begin
      mem[newestPtr]         <= inEntry;
      mem[newestPtr].overrun <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strb.wrEn)  wrPtr <= nextPtr(wrPtr);
      if (strb.popEn) rdPtr <= nextPtr(rdPtr);
    end
  end
endmodule

// File: rtl/rxStatusFifo.sv
module rxStatusFifo
  import rxStatusFifoPkg::*;
#(
  parameter int DEPTH     = 8,
  parameter int HALF_FREE = 4,
  parameter int AGE_LIMIT = 30
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        pushValid,
  input  logic [7:0]  pushData,
  input  logic        pushFrameErr,
  input  logic        pushParityErr,
  input  logic        pushBreak,
  input  logic        bitTick,
  input  logic        readStrobe,
  input  logic        enFull,
  input  logic        enHalf,
  input  logic        enReady,
  input  logic        enOld,
  output logic [15:0] readWord,
  output logic        irqFull,
  output logic        irqHalf,
  output logic        irqReady,
  output logic        irqOld
);
  fifoStrobes_t strb;
  rxEntry_t     inEntry;
  rxEntry_t     headEntry;
  logic isFull, isHalf, isReady, isOld;

  always_comb begin
    inEntry.overrun   = 1'b0;
    inEntry.frameErr  = pushFrameErr;
    inEntry.parityErr = pushParityErr;
    inEntry.breakDet  = pushBreak;
    inEntry.data      = pushData;
  end

  rxFifoCtrl #(.DEPTH(DEPTH), .HALF_FREE(HALF_FREE), .AGE_LIMIT(AGE_LIMIT)) i_ctrl (
    .clk(clk), .rstN(rstN), .pushValid(pushValid), .readStrobe(readStrobe),
    .bitTick(bitTick), .strb(strb), .isFull(isFull), .isHalf(isHalf),
    .isReady(isReady), .isOld(isOld)
  );

  rxFifoData #(.DEPTH(DEPTH)) i_data (
    .clk(clk), .rstN(rstN), .strb(strb), .inEntry(inEntry), .headEntry(headEntry)
  );

  assign readWord = {isFull, isHalf, isReady, isOld,
                     isReady ? 12'(headEntry) : 12'h000};

  assign irqFull  = isFull  && enFull;
  assign irqHalf  = isHalf  && enHalf;
  assign irqReady = isReady && enReady;
  assign irqOld   = isOld   && enOld;
endmodule

// File: rtl/rxStatusFifoChecker.sv
module rxStatusFifoChecker (
  input logic        clk,
  input logic        rstN,
  input logic        pushValid,
  input logic        bitTick,
  input logic        readStrobe,
  input logic [15:0] readWord
);
  AST_EMPTY_FIELDS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !readWord[13] |-> (readWord[12:0] == 13'h0)); // R2

  AST_EMPTY_STAYS_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    (!readWord[13] && !pushValid) |=> !readWord[13]); // R7

  AST_FULL_STAYS_ON_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (readWord[15] && pushValid && !readStrobe) |=> readWord[15]); // R6

  AST_FULL_NEEDS_HALF: assert property (@(posedge clk) disable iff (!rstN)
    readWord[15] |-> readWord[14]); // R4

  AST_READ_CLEARS_OLD: assert property (@(posedge clk) disable iff (!rstN)
    (readStrobe && readWord[13]) |=> !readWord[12]); // R8

  AST_OLD_RISES_ON_TICK: assert property (@(posedge clk) disable iff (!rstN)
    $rose(readWord[12]) |-> $past(bitTick)); // R8
endmodule

bind rxStatusFifo rxStatusFifoChecker i_chk (.*);

// File: tb/test_rxStatusFifo.sv
module test_rxStatusFifo;
  localparam int DEPTH = 8;
  localparam int HALF_FREE = 4;
  localparam int AGE_LIMIT = 30;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pushValid = 0, pushFrameErr = 0, pushParityErr = 0, pushBreak = 0;
  logic [7:0] pushData = '0;
  logic bitTick = 0, readStrobe = 0;
  logic enFull = 0, enHalf = 0, enReady = 0, enOld = 0;
  logic [15:0] readWord;
  logic irqFull, irqHalf, irqReady, irqOld;

  int vectors = 0;
  int fails = 0;
  logic [11:0] q[$];
  int age = 0;

  always #10 clk = ~clk;

  rxStatusFifo #(.DEPTH(DEPTH), .HALF_FREE(HALF_FREE), .AGE_LIMIT(AGE_LIMIT)) i_rxStatusFifo (
    .clk(clk), .rstN(rstN), .pushValid(pushValid), .pushData(pushData),
    .pushFrameErr(pushFrameErr), .pushParityErr(pushParityErr), .pushBreak(pushBreak),
    .bitTick(bitTick), .readStrobe(readStrobe), .enFull(enFull), .enHalf(enHalf),
    .enReady(enReady), .enOld(enOld), .readWord(readWord), .irqFull(irqFull),
    .irqHalf(irqHalf), .irqReady(irqReady), .irqOld(irqOld)
  );

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] expWord();
    logic [15:0] w;
    int n = q.size();
    w[15] = (n == DEPTH);
    w[14] = ((DEPTH - n) <= HALF_FREE);
    w[13] = (n != 0);
    w[12] = (n != 0) && (age > AGE_LIMIT);
    w[11:0] = (n != 0) ? q[0] : 12'h000;
    return w;
  endfunction

  task automatic compareAll();
    logic [15:0] e = expWord();
    chk(readWord[15:15], e[15:15], "R3");
    chk(readWord[14:14], e[14:14], "R4");
    chk(readWord[13:13], e[13:13], "R2");
    chk(readWord[12:12], e[12:12], "R8");
    chk(readWord[11:11], e[11:11], "R6");
    chk(readWord[10:0], e[10:0], "R5");
    chk({12'h0, irqFull, irqHalf, irqReady, irqOld},
        {12'h0, e[15] & enFull, e[14] & enHalf, e[13] & enReady, e[12] & enOld}, "R10");
  endtask

  // One clock: drive now (after negedge), model the edge, compare at next negedge
  task automatic step(input logic psh, input logic [7:0] d, input logic [2:0] fl,
                      input logic tk, input logic rd);
    int pre;
    logic pop;
    pushValid = psh; pushData = d;
    {pushFrameErr, pushParityErr, pushBreak} = fl;
    bitTick = tk; readStrobe = rd;
    @(posedge clk);
    pre = q.size();
    pop = rd && (pre != 0);
    if (pop || (psh && pre == 0)) age = 0;
    else if (tk && pre != 0 && age <= AGE_LIMIT) age++;
    if (pop) void'(q.pop_front());
    if (psh) begin
      if (pre == DEPTH && !pop) q[q.size()-1] = {1'b1, fl, d};
      else q.push_back({1'b0, fl, d});
    end
    @(negedge clk);
    pushValid = 0; bitTick = 0; readStrobe = 0;
    compareAll();
  endtask

  initial begin : watchdog
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog: actual running expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(readWord, 16'h0000, "R1");
    rstN = 1'b1;
    @(negedge clk);
    chk(readWord, 16'h0000, "R1");
    {enFull, enHalf, enReady, enOld} = 4'b1111;

    // R5/R3/R4: fill with distinct data and flag patterns
    for (int i = 0; i < DEPTH; i++) step(1'b1, 8'(8'h31 * i + 8'h5), 3'(i), 1'b0, 1'b0);
    // R6: overflow twice, newest replaced and tagged
    step(1'b1, 8'hA5, 3'b101, 1'b0, 1'b0);
    step(1'b1, 8'h5A, 3'b010, 1'b0, 1'b0);
    // R9: push and read together on full, no tag
    step(1'b1, 8'hC3, 3'b111, 1'b0, 1'b1);
    {enFull, enHalf, enReady, enOld} = 4'b1010;
    // R5: drain and check order
    for (int i = 0; i < DEPTH; i++) step(1'b0, 8'h00, 3'b000, 1'b0, 1'b1);
    // R7: reads on empty
    step(1'b0, 8'h00, 3'b000, 1'b0, 1'b1);
    step(1'b0, 8'h00, 3'b000, 1'b1, 1'b1);
    {enFull, enHalf, enReady, enOld} = 4'b0101;

    // R8: threshold at exactly 30 and 31 ticks
    step(1'b1, 8'h77, 3'b000, 1'b0, 1'b0);
    for (int i = 0; i < AGE_LIMIT; i++) step(1'b0, 8'h00, 3'b000, 1'b1, 1'b0);
    step(1'b1, 8'h78, 3'b001, 1'b0, 1'b0);   // push to non-empty: no restart
    step(1'b0, 8'h00, 3'b000, 1'b1, 1'b0);   // 31st tick -> old
    step(1'b0, 8'h00, 3'b000, 1'b1, 1'b0);
    step(1'b0, 8'h00, 3'b000, 1'b0, 1'b1);   // read clears old
    for (int i = 0; i < 20; i++) step(1'b0, 8'h00, 3'b000, 1'b1, 1'b0);
    step(1'b0, 8'h00, 3'b000, 1'b1, 1'b1);   // read during ticks restarts
    for (int i = 0; i < 12; i++) step(1'b0, 8'h00, 3'b000, 1'b1, 1'b0);

    // R9: push and read together on partial store
    {enFull, enHalf, enReady, enOld} = 4'b1111;
    for (int i = 0; i < 5; i++) step(1'b1, 8'(8'h90 + i), 3'(7 - i), 1'b0, 1'b0);
    for (int i = 0; i < 6; i++) step(1'b1, 8'(8'hE0 + i), 3'(i), 1'b1, 1'b1);
    for (int i = 0; i < 8; i++) step(1'b0, 8'h00, 3'b000, 1'b0, 1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule